// File: doc/BRIEF.md
# Byte-Wide Strobed I/O Port

This block is an 8-bit parallel port that a processor bus reaches through a pair of decode lines. A mode pin sets its role. As an output latch, it takes a byte from the data bus during a qualified write cycle, on the cycle that carries the bus timing pulse. It holds that byte on its pad outputs until the next such cycle. As an input latch, it samples the external pads when an external strobe rises. It raises a service-request flag and places the held byte on the data bus while the processor selects it for an I/O read.

Two enables act separately. The input enable stops pad capture. The output enable turns off the pad driver only. Tri-state behaviour is modelled with output-enable signals: when the port is not driving the bus, `bus_oe_o` is low and `bus_d_o` reads zero. Everything is synchronous to `clk_i`, and an active-low asynchronous reset clears all state.

Top module: `strobed_io_port`

## Requirements
- R1: After reset, the pad output byte is 0x00, the service request is low, and the input register reads 0x00 over the bus.
- R2: `bus_oe_o` is high, in the same cycle, exactly when mode is input (`mode_i`=1), `addr_sel_i`=1, `cmd_sel_i`=1 and `mem_rd_i`=0. `bus_d_o` is 0x00 whenever `bus_oe_o` is low.
- R3: In input mode with `in_en_i`=1, a clock edge at which `stb_i` is 1 and was 0 at the previous edge latches `pad_d_i`. A strobe held high across further edges latches nothing more.
- R4: With `in_en_i`=0, a strobe rise changes neither the input register nor the service request.
- R5: `srq_o` goes high on the edge that latches input data. It goes low on an edge where the R2 read select is active. When a capture and a read select meet on the same edge, the flag stays high.
- R6: In output mode (`mode_i`=0), the edge where `addr_sel_i`, `cmd_sel_i`, `mem_rd_i` and `tpb_i` are all 1 loads `bus_d_i` into the output register, shown on `pad_d_o`. At every other edge the register holds its value.
- R7: `pad_oe_o` is high exactly when mode is output and `out_en_i`=1. `out_en_i` does not block the R6 capture.
- R8: A qualified output strobe in input mode leaves `pad_d_o` unchanged. A strobe rise in output mode leaves the input register and `srq_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = input latch, 0 = output latch |
| in_en_i | input | 1 | Enables pad capture |
| out_en_i | input | 1 | Enables the pad driver |
| addr_sel_i | input | 1 | Address decode line |
| cmd_sel_i | input | 1 | Command decode line |
| mem_rd_i | input | 1 | Memory-read cycle indicator |
| tpb_i | input | 1 | Bus timing pulse |
| stb_i | input | 1 | External input strobe |
| bus_d_i | input | 8 | Data bus into the port |
| bus_d_o | output | 8 | Data bus driven by the port |
| bus_oe_o | output | 1 | Bus drive enable |
| pad_d_i | input | 8 | External pad data in |
| pad_d_o | output | 8 | Pad data out |
| pad_oe_o | output | 1 | Pad drive enable |
| srq_o | output | 1 | Service request flag |

## Verification
`bus_oe_o`, `pad_oe_o` and `bus_d_o` are combinational from the inputs and registers, so the bench checks them a fraction of a nanosecond after it drives the inputs. A capture into either register, and any change of `srq_o`, is due one clock edge after its qualifying inputs. The bench drives inputs after a falling edge and updates its expected values at the next rising edge. It compares results at the following falling edge, half a cycle after they settle. Reading the input register costs no cycle: it is checked through the combinational read path in the same step in which the select is applied.

// File: rtl/strobed_io_pkg.sv
package strobed_io_pkg;
  typedef enum logic {
    PORT_OUT = 1'b0,
    PORT_IN  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/io_sel_decode.sv
module io_sel_decode
  import strobed_io_pkg::*;
(
  input  logic mode_i,
  input  logic addr_sel_i,
  input  logic cmd_sel_i,
  input  logic mem_rd_i,
  input  logic tpb_i,
  output logic rd_sel_o,
  output logic wr_stb_o
);
  logic both_sel;

  assign both_sel = addr_sel_i & cmd_sel_i;
  // read path: port drives bus while memory is not reading
  assign rd_sel_o = both_sel & ~mem_rd_i & (port_mode_e'(mode_i) == PORT_IN);
  // write path: bus holds memory data, taken on the timing pulse
  assign wr_stb_o = both_sel & mem_rd_i & tpb_i & (port_mode_e'(mode_i) == PORT_OUT);
endmodule

// File: rtl/io_in_latch.sv
module io_in_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o,
  output logic         srq_o
);
  logic         stb_q;
  logic         cap;
  logic [W-1:0] data_q;
  logic         srq_q;

  assign cap = en_i & stb_i & ~stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q  <= 1'b0;
      data_q <= '0;
      srq_q  <= 1'b0;
    end else begin
      stb_q <= stb_i;
      if (cap) data_q <= d_i;
      if (cap)       srq_q <= 1'b1;
      else if (rd_i) srq_q <= 1'b0;
    end
  end

  assign q_o   = data_q;
  assign srq_o = srq_q;

  AST_CAP_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (data_q == $past(d_i)) && srq_q); // R3
  AST_NO_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(data_q)); // R4
  AST_SRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !cap) |=> !srq_q); // R5
  AST_HELD_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && stb_q) |=> $stable(data_q)); // R3
endmodule

// File: rtl/io_out_latch.sv
module io_out_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (stb_i) data_q <= d_i;
  end

  assign q_o = data_q;

  AST_OUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> data_q == $past(d_i)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(data_q)); // R6
endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port
  import strobed_io_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              in_en_i,
  input  logic              out_en_i,
  input  logic              addr_sel_i,
  input  logic              cmd_sel_i,
  input  logic              mem_rd_i,
  input  logic              tpb_i,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] pad_d_i,
  output logic [DATA_W-1:0] pad_d_o,
  output logic              pad_oe_o,
  output logic              srq_o
);
  logic              rd_sel;
  logic              wr_stb;
  logic              in_mode;
  logic [DATA_W-1:0] in_q;

  assign in_mode = (port_mode_e'(mode_i) == PORT_IN);

  io_sel_decode u_dec (
    .mode_i    (mode_i),
    .addr_sel_i(addr_sel_i),
    .cmd_sel_i (cmd_sel_i),
    .mem_rd_i  (mem_rd_i),
    .tpb_i     (tpb_i),
    .rd_sel_o  (rd_sel),
    .wr_stb_o  (wr_stb)
  );

  io_in_latch #(.W(DATA_W)) u_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (in_mode & in_en_i),
    .stb_i (stb_i),
    .d_i   (pad_d_i),
    .rd_i  (rd_sel),
    .q_o   (in_q),
    .srq_o (srq_o)
  );

  io_out_latch #(.W(DATA_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (wr_stb),
    .d_i   (bus_d_i),
    .q_o   (pad_d_o)
  );

  assign bus_oe_o = rd_sel;
  assign bus_d_o  = rd_sel ? in_q : '0;
  assign pad_oe_o = ~in_mode & out_en_i;

  AST_IN_MODE_PAD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> $stable(pad_d_o)); // R8
  AST_OUT_MODE_SRQ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !srq_o) |=> !srq_o); // R8
  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_sel_i && cmd_sel_i) |-> !bus_oe_o); // R2
endmodule

// File: tb/strobed_io_port_bench.sv
`timescale 1ns/1ps
module strobed_io_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, in_en = 1'b0, out_en = 1'b0;
  logic       addr = 1'b0, cmd = 1'b0, mrd = 1'b0, tpb = 1'b0, stb = 1'b0;
  logic [7:0] bus_in = 8'h00, pad_in = 8'h00;
  logic [7:0] bus_out, pad_out;
  logic       bus_oe, pad_oe, srq;

  int checks = 0;
  int errors = 0;
  logic       done = 1'b0;

  // expected state
  logic [7:0] e_in = 8'h00, e_out = 8'h00;
  logic       e_srq = 1'b0, e_prev = 1'b0;

  always #2 clk = ~clk;

  strobed_io_port u_strobed_io_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .in_en_i(in_en), .out_en_i(out_en),
    .addr_sel_i(addr), .cmd_sel_i(cmd), .mem_rd_i(mrd), .tpb_i(tpb), .stb_i(stb),
    .bus_d_i(bus_in), .bus_d_o(bus_out), .bus_oe_o(bus_oe),
    .pad_d_i(pad_in), .pad_d_o(pad_out), .pad_oe_o(pad_oe), .srq_o(srq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic rd_sel_f();
    return mode & addr & cmd & ~mrd;
  endfunction

  // combinational checks right after driving
  task automatic comb_chk();
    #0.5;
    chk("R2 bus_oe", {7'd0, bus_oe}, {7'd0, rd_sel_f()});
    chk("R2 bus_d", bus_out, rd_sel_f() ? e_in : 8'h00);
    chk("R7 pad_oe", {7'd0, pad_oe}, {7'd0, ~mode & out_en});
  endtask

  // one clock: update expectation at rising edge, check at falling edge
  task automatic step(input string tag);
    logic cap_in, cap_out, rd;
    @(posedge clk);
    cap_in  = mode & in_en & stb & ~e_prev;
    cap_out = ~mode & addr & cmd & mrd & tpb;
    rd      = rd_sel_f();
    if (cap_in) e_in = pad_in;
    if (cap_in) e_srq = 1'b1;
    else if (rd) e_srq = 1'b0;
    e_prev = stb;
    if (cap_out) e_out = bus_in;
    @(negedge clk);
    chk({tag, " R6 pad_d"}, pad_out, e_out);
    chk({tag, " R5 srq"}, {7'd0, srq}, {7'd0, e_srq});
  endtask

  task automatic read_in(input string tag, input logic [7:0] exp);
    mode = 1'b1; addr = 1'b1; cmd = 1'b1; mrd = 1'b0; stb = 1'b0;
    #0.5;
    chk(tag, bus_out, exp);
    step(tag);
    addr = 1'b0; cmd = 1'b0;
  endtask

  initial begin
    #3;
    chk("R1 pad_d", pad_out, 8'h00);
    chk("R1 srq", {7'd0, srq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    read_in("R1 in_reg", 8'h00);

    // R3: leading edge capture, held strobe captures once
    mode = 1'b1; in_en = 1'b1; addr = 1'b0; cmd = 1'b0;
    pad_in = 8'hA5; stb = 1'b1; step("R3 rise");
    chk("R3 srq set", {7'd0, srq}, 8'h01);
    pad_in = 8'h3C; step("R3 held");
    read_in("R3 held value", 8'hA5);
    chk("R5 srq cleared", {7'd0, srq}, 8'h00);

    // R4: disabled input
    in_en = 1'b0; pad_in = 8'h77; stb = 1'b1; step("R4 dis");
    chk("R4 srq", {7'd0, srq}, 8'h00);
    read_in("R4 in_reg", 8'hA5);

    // R5: capture and read on same edge
    in_en = 1'b1; pad_in = 8'h5A; stb = 1'b0; step("R5 pre");
    stb = 1'b1; addr = 1'b1; cmd = 1'b1; mrd = 1'b0; step("R5 both");
    chk("R5 capture wins", {7'd0, srq}, 8'h01);
    read_in("R5 data", 8'h5A);

    // R8: output strobe in input mode; input strobe in output mode
    mode = 1'b1; addr = 1'b1; cmd = 1'b1; mrd = 1'b1; tpb = 1'b1; bus_in = 8'hEE;
    step("R8 in-mode");
    chk("R8 pad kept", pad_out, 8'h00);
    mode = 1'b0; tpb = 1'b0; addr = 1'b0; stb = 1'b0; step("R8 idle");
    pad_in = 8'h11; stb = 1'b1; step("R8 out-mode stb");
    chk("R8 srq kept", {7'd0, srq}, 8'h00);
    read_in("R8 in_reg kept", 8'h5A);

    // R6/R7: qualified write with driver off
    mode = 1'b0; out_en = 1'b0; addr = 1'b1; cmd = 1'b1; mrd = 1'b1; tpb = 1'b1;
    bus_in = 8'hC3; comb_chk(); step("R7 drv off");
    chk("R7 capture with driver off", pad_out, 8'hC3);

    // sweep of all control combinations
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      c = i[7:0];
      mode = c[0]; addr = c[1]; cmd = c[2]; mrd = c[3];
      tpb = c[4]; in_en = c[5]; stb = c[6]; out_en = c[7];
      bus_in = 8'(i * 29 + 3);
      pad_in = 8'(i * 53 + 17);
      comb_chk();
      step("sweep");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule